// File: doc/BRIEF.md
# CAN Fault Confinement and Interrupt Controller

This block tracks the transmit and receive error counters of a CAN node and turns them into a fault-confinement state: error-active, warning, error-passive or bus-off. A protocol engine feeds it single-cycle pulses for transmit and receive errors, for frames that complete without error, for the bit, form and stuff error types, and for a received frame that was lost because no buffer was free. From these the block keeps sticky global interrupt status bits, a per-bit interrupt mask, a masked flag word and one interrupt line.

The block also runs two mode handshakes for software. A configuration request is acknowledged after a fixed latency and holds the counters at zero while it is active. A sleep request is acknowledged the same way and is left by writing zero to a dedicated register. A software reset bit clears the counters and all sticky status. A bus-off recovery pulse from the protocol engine clears both counters. Software reaches all of this through a simple single-cycle write port and a combinational read port, with eight word addresses.

Top module: `can_fault_ctrl`

## Requirements
- R1: After reset every counter, status, mask and acknowledge reads zero. The counter word (address 2, port cnt_word) holds the receive count in bits 7:0 and the transmit count in bits 15:8.
- R2: A transmit error pulse adds 8 to the transmit count and a receive error pulse adds 1 to the receive count. The receive count saturates at 255.
- R3: A success pulse subtracts 1 from its counter and stops at 0. When an error pulse and a success pulse reach the same counter in one cycle, only the error counts.
- R4: fc_state (also status register bits 1:0) encodes 0 active, 1 warning (either count at least 96), 2 passive (either count at least 128), 3 bus-off (transmit count above 255). In bus-off the transmit field reads 0xFF and error and success pulses have no effect on either count.
- R5: Global status bit 0 (transmit warning), bit 1 (receive warning), bit 2 (passive) and bit 3 (bus-off) are set on the clock edge where the counter update makes their condition true. They are not set again while the condition stays true.
- R6: A message-lost pulse sets global status bit 7 on the edge that samples it.
- R7: Writing the global status word (address 4) clears each bit written as 1. A bit that is being set in the same cycle stays set. Bits 4 to 6 and 8 to 10 always read 0.
- R8: The error status word (address 3) latches a bit error at bit 6, a form error at bit 7 and a stuff error at bit 3. Each bit is cleared by writing 1 to it, and a bit that is being set in the same cycle stays set.
- R9: The flag word (address 6) is the global status ANDed with the mask word (address 5). irq is high exactly when the flag word is nonzero.
- R10: Writing control (address 0) with bit 7 set requests configuration. The acknowledge reads at bit 7 of control and bit 7 of status. It rises on the second clock edge after the write and falls on the first edge after the request is written to 0. While the request or the acknowledge is high, both counts are held at 0 and count pulses are ignored.
- R11: Control bit 5 requests sleep and reads back as written. The sleep acknowledge reads at bit 3 of address 7 and rises on the second edge after the request. Writing 0 to address 7 clears both the acknowledge and the request.
- R12: Writing control with bit 0 set clears both counts, the global status and the error status on that edge, overriding any event in the same cycle. The mask is kept, and bit 0 reads back as 0.
- R13: A bus-off recovery pulse clears both counts and returns fc_state to active. Sticky status bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_rx_err | input | 1 | Receive error pulse |
| ev_tx_ok | input | 1 | Frame sent without error |
| ev_rx_ok | input | 1 | Frame received without error |
| ev_bit_err | input | 1 | Bit error detected |
| ev_form_err | input | 1 | Form error detected |
| ev_stuff_err | input | 1 | Stuff error detected |
| ev_msg_lost | input | 1 | Received frame lost |
| bo_recover | input | 1 | Bus-off recovery done, clears counts |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| cnt_word | output | 16 | Packed error counters |
| err_stat | output | 16 | Latched error type flags |
| gis_word | output | 11 | Global interrupt status |
| gif_word | output | 11 | Masked interrupt flags |
| irq | output | 1 | Interrupt line |
| fc_state | output | 2 | Fault-confinement state |

## Verification
The same-cycle case that matters is a status bit being set by an event in the cycle software writes a 1 to clear it. This applies to the message-lost bit of the global status word and to the stuff bit of the error status word. The bench raises the event pulse and the clearing write in one cycle. It then requires the bit to read as set, and to clear only after a later write with no event. A second overlap, an error pulse and a success pulse on the same counter, is driven from the stimulus table and judged by the resulting count.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_WARNING = 2'd1,
    FC_PASSIVE = 2'd2,
    FC_BUSOFF  = 2'd3
  } fc_state_e;

  typedef struct packed {
    logic busoff;
    logic passive;
    logic rx_warn;
    logic tx_warn;
  } fc_cond_t;

  // register word addresses
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_ESR  = 3'd3;
  localparam logic [2:0] RA_GIS  = 3'd4;
  localparam logic [2:0] RA_GIM  = 3'd5;
  localparam logic [2:0] RA_GIF  = 3'd6;
  localparam logic [2:0] RA_SLP  = 3'd7;

  // global status bit positions
  localparam int GS_TXW   = 0;
  localparam int GS_RXW   = 1;
  localparam int GS_PAS   = 2;
  localparam int GS_BOF   = 3;
  localparam int GS_MLOST = 7;

  // error status bit positions
  localparam int ES_STUFF = 3;
  localparam int ES_BIT   = 6;
  localparam int ES_FORM  = 7;

  // control / sleep register bit positions
  localparam int CT_SRST  = 0;
  localparam int CT_SLEEP = 5;
  localparam int CT_CFG   = 7;
  localparam int SL_ACK   = 3;

endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters
  import can_fc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TX_INC   = 8,
  parameter int RX_INC   = 1,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tx_err,
  input  logic               rx_err,
  input  logic               tx_ok,
  input  logic               rx_ok,
  output logic [CNT_W:0]     tec_q,
  output logic [CNT_W-1:0]   rec_q,
  output fc_cond_t           cond_q,
  output fc_cond_t           cond_rise
);

  localparam int TEC_W = CNT_W + 1;
  localparam logic [TEC_W-1:0] T_INC  = TEC_W'(TX_INC);
  localparam logic [TEC_W-1:0] R_INC  = TEC_W'(RX_INC);
  localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LIM);
  localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASS_LIM);
  localparam logic [CNT_W-1:0] R_WARN = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] R_PASS = CNT_W'(PASS_LIM);

  logic [TEC_W-1:0] tec_d;
  logic [CNT_W-1:0] rec_d;
  logic [TEC_W-1:0] rec_sum;
  logic             cnt_en;
  fc_cond_t         cond_d;

  function automatic fc_cond_t cond_of(input logic [TEC_W-1:0] t,
                                       input logic [CNT_W-1:0] r);
    fc_cond_t c;
    c.tx_warn = (t >= T_WARN);
    c.rx_warn = (r >= R_WARN);
    c.passive = (t >= T_PASS) || (r >= R_PASS);
    c.busoff  = t[CNT_W];
    return c;
  endfunction

  always_comb begin
    tec_d   = tec_q;
    rec_d   = rec_q;
    rec_sum = {1'b0, rec_q} + R_INC;
    if (clr) begin
      tec_d = '0;
      rec_d = '0;
    end else if (!tec_q[CNT_W]) begin
      if (tx_err) begin
        tec_d = tec_q + T_INC;
      end else if (tx_ok && (tec_q != '0)) begin
        tec_d = tec_q - 1'b1;
      end
      if (rx_err) begin
        rec_d = rec_sum[CNT_W] ? '1 : rec_sum[CNT_W-1:0];
      end else if (rx_ok && (rec_q != '0)) begin
        rec_d = rec_q - 1'b1;
      end
    end
  end

  assign cnt_en    = (tec_d != tec_q) || (rec_d != rec_q);
  assign cond_q    = cond_of(tec_q, rec_q);
  assign cond_d    = cond_of(tec_d, rec_d);
  assign cond_rise = cond_d & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (cnt_en) begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

endmodule

// File: rtl/can_fc_hs.sv
module can_fc_hs #(
  parameter int ACK_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic ack
);

  localparam int LAT_W = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(ACK_LAT - 1);

  logic             ack_q, ack_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             hs_en;

  always_comb begin
    ack_d = ack_q;
    cnt_d = cnt_q;
    if (clr || !req) begin
      ack_d = 1'b0;
      cnt_d = '0;
    end else if (!ack_q) begin
      if (cnt_q == LAT_LAST) begin
        ack_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign hs_en = (ack_d != ack_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else if (hs_en) begin
      ack_q <= ack_d;
      cnt_q <= cnt_d;
    end
  end

  assign ack = ack_q;

endmodule

// File: rtl/can_fc_irq.sv
module can_fc_irq
  import can_fc_pkg::*;
#(
  parameter int GIS_W = 11,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  fc_cond_t         cond_rise,
  input  logic             msg_lost,
  input  logic             bit_err,
  input  logic             form_err,
  input  logic             stuff_err,
  input  logic [GIS_W-1:0] gis_w1c,
  input  logic [REG_W-1:0] esr_w1c,
  input  logic             gim_we,
  input  logic [GIS_W-1:0] gim_wdata,
  output logic [GIS_W-1:0] gis,
  output logic [GIS_W-1:0] gim,
  output logic [REG_W-1:0] esr,
  output logic [GIS_W-1:0] gif,
  output logic             irq
);

  logic [GIS_W-1:0] gis_q, gis_d, gis_set;
  logic [GIS_W-1:0] gim_q, gim_d;
  logic [REG_W-1:0] esr_q, esr_d, esr_set;
  logic             gis_en, gim_en, esr_en;

  always_comb begin
    gis_set            = '0;
    gis_set[GS_TXW]    = cond_rise.tx_warn;
    gis_set[GS_RXW]    = cond_rise.rx_warn;
    gis_set[GS_PAS]    = cond_rise.passive;
    gis_set[GS_BOF]    = cond_rise.busoff;
    gis_set[GS_MLOST]  = msg_lost;
    esr_set            = '0;
    esr_set[ES_BIT]    = bit_err;
    esr_set[ES_FORM]   = form_err;
    esr_set[ES_STUFF]  = stuff_err;
  end

  always_comb begin
    if (clr_all) begin
      gis_d = '0;
      esr_d = '0;
    end else begin
      gis_d = (gis_q & ~gis_w1c) | gis_set;
      esr_d = (esr_q & ~esr_w1c) | esr_set;
    end
    gim_d = gim_we ? gim_wdata : gim_q;
  end

  assign gis_en = (gis_d != gis_q);
  assign esr_en = (esr_d != esr_q);
  assign gim_en = gim_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gis_q <= '0;
    end else if (gis_en) begin
      gis_q <= gis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esr_q <= '0;
    end else if (esr_en) begin
      esr_q <= esr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gim_q <= '0;
    end else if (gim_en) begin
      gim_q <= gim_d;
    end
  end

  assign gis = gis_q;
  assign gim = gim_q;
  assign esr = esr_q;
  assign gif = gis_q & gim_q;
  assign irq = |gif;

endmodule

// File: rtl/can_fault_ctrl.sv
module can_fault_ctrl
  import can_fc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TX_INC   = 8,
  parameter int RX_INC   = 1,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int ACK_LAT  = 2,
  parameter int GIS_W    = 11,
  parameter int REG_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tx_err,
  input  logic             ev_rx_err,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  input  logic             ev_bit_err,
  input  logic             ev_form_err,
  input  logic             ev_stuff_err,
  input  logic             ev_msg_lost,
  input  logic             bo_recover,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] cnt_word,
  output logic [REG_W-1:0] err_stat,
  output logic [GIS_W-1:0] gis_word,
  output logic [GIS_W-1:0] gif_word,
  output logic             irq,
  output logic [1:0]       fc_state
);

  localparam int TEC_W = CNT_W + 1;

  logic             wr_ctrl, srst, slp_leave, gim_we;
  logic             cfg_req_q, cfg_req_d, slp_req_q, slp_req_d, ctrl_en;
  logic             cfg_ack, slp_ack, cnt_clr;
  logic [TEC_W-1:0] tec_q;
  logic [CNT_W-1:0] rec_q, tx_view;
  fc_cond_t         cond_q, cond_rise;
  fc_state_e        state;
  logic [GIS_W-1:0] gis, gim, gif, gis_w1c;
  logic [REG_W-1:0] esr, esr_w1c;

  // register write decode
  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign srst      = wr_ctrl && reg_wdata[CT_SRST];
  assign slp_leave = reg_wr && (reg_addr == RA_SLP) && (reg_wdata == '0);
  assign gim_we    = reg_wr && (reg_addr == RA_GIM);
  assign gis_w1c   = (reg_wr && (reg_addr == RA_GIS)) ? reg_wdata[GIS_W-1:0] : '0;
  assign esr_w1c   = (reg_wr && (reg_addr == RA_ESR)) ? reg_wdata : '0;

  // mode request register
  always_comb begin
    cfg_req_d = cfg_req_q;
    slp_req_d = slp_req_q;
    if (wr_ctrl) begin
      cfg_req_d = reg_wdata[CT_CFG];
      slp_req_d = reg_wdata[CT_SLEEP];
    end else if (slp_leave) begin
      slp_req_d = 1'b0;
    end
  end

  assign ctrl_en = wr_ctrl || slp_leave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_req_q <= 1'b0;
      slp_req_q <= 1'b0;
    end else if (ctrl_en) begin
      cfg_req_q <= cfg_req_d;
      slp_req_q <= slp_req_d;
    end
  end

  can_fc_hs #(.ACK_LAT(ACK_LAT)) u_cfg_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cfg_req_q),
    .clr   (srst),
    .ack   (cfg_ack)
  );

  can_fc_hs #(.ACK_LAT(ACK_LAT)) u_slp_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (slp_req_q),
    .clr   (srst || slp_leave),
    .ack   (slp_ack)
  );

  // error counters
  assign cnt_clr = srst || cfg_req_q || cfg_ack || bo_recover;

  can_fc_counters #(
    .CNT_W    (CNT_W),
    .TX_INC   (TX_INC),
    .RX_INC   (RX_INC),
    .WARN_LIM (WARN_LIM),
    .PASS_LIM (PASS_LIM)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .tx_err    (ev_tx_err),
    .rx_err    (ev_rx_err),
    .tx_ok     (ev_tx_ok),
    .rx_ok     (ev_rx_ok),
    .tec_q     (tec_q),
    .rec_q     (rec_q),
    .cond_q    (cond_q),
    .cond_rise (cond_rise)
  );

  always_comb begin
    if (cond_q.busoff)                         state = FC_BUSOFF;
    else if (cond_q.passive)                   state = FC_PASSIVE;
    else if (cond_q.tx_warn || cond_q.rx_warn) state = FC_WARNING;
    else                                       state = FC_ACTIVE;
  end

  assign tx_view = tec_q[CNT_W] ? '1 : tec_q[CNT_W-1:0];

  // status, mask and interrupt
  can_fc_irq #(.GIS_W(GIS_W), .REG_W(REG_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (srst),
    .cond_rise (cond_rise),
    .msg_lost  (ev_msg_lost),
    .bit_err   (ev_bit_err),
    .form_err  (ev_form_err),
    .stuff_err (ev_stuff_err),
    .gis_w1c   (gis_w1c),
    .esr_w1c   (esr_w1c),
    .gim_we    (gim_we),
    .gim_wdata (reg_wdata[GIS_W-1:0]),
    .gis       (gis),
    .gim       (gim),
    .esr       (esr),
    .gif       (gif),
    .irq       (irq)
  );

  // read port
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CT_CFG]   = cfg_ack;
        reg_rdata[CT_SLEEP] = slp_req_q;
      end
      RA_STAT: begin
        reg_rdata[1:0]    = state;
        reg_rdata[CT_CFG] = cfg_ack;
      end
      RA_CNT:  reg_rdata = cnt_word;
      RA_ESR:  reg_rdata = esr;
      RA_GIS:  reg_rdata[GIS_W-1:0] = gis;
      RA_GIM:  reg_rdata[GIS_W-1:0] = gim;
      RA_GIF:  reg_rdata[GIS_W-1:0] = gif;
      RA_SLP:  reg_rdata[SL_ACK] = slp_ack;
      default: reg_rdata = '0;
    endcase
  end

  assign cnt_word = REG_W'({tx_view, rec_q});
  assign err_stat = esr;
  assign gis_word = gis;
  assign gif_word = gif;
  assign fc_state = state;

endmodule

// File: rtl/can_fault_ctrl_chk.sv
module can_fault_ctrl_chk
  import can_fc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GIS_W = 11,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             ev_msg_lost,
  input logic             ev_bit_err,
  input logic [REG_W-1:0] cnt_word,
  input logic [REG_W-1:0] err_stat,
  input logic [GIS_W-1:0] gis_word,
  input logic             irq,
  input logic [1:0]       fc_state,
  input logic             cfg_ack,
  input logic             slp_ack
);

  logic srst_w, slp_leave_w, gis_touch;
  assign srst_w      = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CT_SRST];
  assign slp_leave_w = reg_wr && (reg_addr == RA_SLP) && (reg_wdata == '0);
  assign gis_touch   = reg_wr && ((reg_addr == RA_GIS) || (reg_addr == RA_CTRL));

  a_r4_busoff_view: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state == 2'd3) |-> (cnt_word[2*CNT_W-1:CNT_W] == '1));

  a_r6_msg_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_msg_lost && !srst_w) |=> gis_word[GS_MLOST]);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (gis_word[GS_MLOST] && !gis_touch) |=> gis_word[GS_MLOST]);

  a_r8_bit_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bit_err && !srst_w) |=> err_stat[ES_BIT]);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gis_word != '0));

  a_r10_cfg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack |-> (cnt_word == '0));

  a_r11_sleep_leave: assert property (@(posedge clk) disable iff (!rst_n)
    slp_leave_w |=> !slp_ack);

  a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> ((cnt_word == '0) && (gis_word == '0) && (err_stat == '0)));

endmodule

bind can_fault_ctrl can_fault_ctrl_chk #(
  .CNT_W (CNT_W),
  .GIS_W (GIS_W),
  .REG_W (REG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .ev_msg_lost (ev_msg_lost),
  .ev_bit_err  (ev_bit_err),
  .cnt_word    (cnt_word),
  .err_stat    (err_stat),
  .gis_word    (gis_word),
  .irq         (irq),
  .fc_state    (fc_state),
  .cfg_ack     (cfg_ack),
  .slp_ack     (slp_ack)
);

// File: tb/test_can_fault_ctrl.sv
module test_can_fault_ctrl;

  logic        clk;
  logic        rst_n;
  logic        ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok;
  logic        ev_bit_err, ev_form_err, ev_stuff_err, ev_msg_lost, bo_recover;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, cnt_word, err_stat;
  logic [10:0] gis_word, gif_word;
  logic        irq;
  logic [1:0]  fc_state;

  int checks;
  int failures;

  can_fault_ctrl i_can_fault_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_tx_err    (ev_tx_err),
    .ev_rx_err    (ev_rx_err),
    .ev_tx_ok     (ev_tx_ok),
    .ev_rx_ok     (ev_rx_ok),
    .ev_bit_err   (ev_bit_err),
    .ev_form_err  (ev_form_err),
    .ev_stuff_err (ev_stuff_err),
    .ev_msg_lost  (ev_msg_lost),
    .bo_recover   (bo_recover),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .cnt_word     (cnt_word),
    .err_stat     (err_stat),
    .gis_word     (gis_word),
    .gif_word     (gif_word),
    .irq          (irq),
    .fc_state     (fc_state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stimulus table: ev bits 0 tx_err, 1 rx_err, 2 tx_ok, 3 rx_ok, 4 recover
  typedef struct packed {
    logic [4:0]  ev;
    logic [7:0]  rep;
    logic [15:0] cnt;
    logic [1:0]  st;
    logic [10:0] gis;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    {5'h01, 8'd1,   16'h0800, 2'd0, 11'h000},
    {5'h04, 8'd1,   16'h0700, 2'd0, 11'h000},
    {5'h02, 8'd1,   16'h0701, 2'd0, 11'h000},
    {5'h08, 8'd1,   16'h0700, 2'd0, 11'h000},
    {5'h08, 8'd1,   16'h0700, 2'd0, 11'h000},
    {5'h05, 8'd1,   16'h0F00, 2'd0, 11'h000},
    {5'h03, 8'd1,   16'h1701, 2'd0, 11'h000},
    {5'h01, 8'd9,   16'h5F01, 2'd0, 11'h000},
    {5'h01, 8'd1,   16'h6701, 2'd1, 11'h001},
    {5'h04, 8'd1,   16'h6601, 2'd1, 11'h001},
    {5'h01, 8'd4,   16'h8601, 2'd2, 11'h005},
    {5'h01, 8'd15,  16'hFE01, 2'd2, 11'h005},
    {5'h01, 8'd1,   16'hFF01, 2'd3, 11'h00D},
    {5'h02, 8'd1,   16'hFF01, 2'd3, 11'h00D},
    {5'h04, 8'd1,   16'hFF01, 2'd3, 11'h00D},
    {5'h10, 8'd1,   16'h0000, 2'd0, 11'h00D},
    {5'h02, 8'd95,  16'h005F, 2'd0, 11'h00D},
    {5'h02, 8'd1,   16'h0060, 2'd1, 11'h00F},
    {5'h02, 8'd32,  16'h0080, 2'd2, 11'h00F},
    {5'h02, 8'd200, 16'h00FF, 2'd2, 11'h00F},
    {5'h08, 8'd1,   16'h00FE, 2'd2, 11'h00F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] ev, input int rep);
    for (int r = 0; r < rep; r++) begin
      @(negedge clk);
      ev_tx_err  = ev[0];
      ev_rx_err  = ev[1];
      ev_tx_ok   = ev[2];
      ev_rx_ok   = ev[3];
      bo_recover = ev[4];
      @(negedge clk);
      ev_tx_err  = 1'b0;
      ev_rx_err  = 1'b0;
      ev_tx_ok   = 1'b0;
      ev_rx_ok   = 1'b0;
      bo_recover = 1'b0;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic one_pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_bit_err   = 1'b1;
      1: ev_form_err  = 1'b1;
      2: ev_stuff_err = 1'b1;
      default: ev_msg_lost = 1'b1;
    endcase
    @(negedge clk);
    ev_bit_err   = 1'b0;
    ev_form_err  = 1'b0;
    ev_stuff_err = 1'b0;
    ev_msg_lost  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    ev_tx_err = 0; ev_rx_err = 0; ev_tx_ok = 0; ev_rx_ok = 0;
    ev_bit_err = 0; ev_form_err = 0; ev_stuff_err = 0; ev_msg_lost = 0;
    bo_recover = 0; reg_wr = 0; reg_addr = 3'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cnt", cnt_word, 0);
    chk("R1 gis", gis_word, 0);
    chk("R1 esr", err_stat, 0);
    chk("R1 irq", irq, 0);
    rd(3'd1, d); chk("R1 stat", d, 0);
    rd(3'd5, d); chk("R1 gim", d, 0);

    // table walk: R1 R2 R3 R4 R5 R13
    for (int i = 0; i < NVEC; i++) begin
      pulse(VEC[i].ev, int'(VEC[i].rep));
      chk($sformatf("R2/R3 table %0d cnt", i), cnt_word, VEC[i].cnt);
      chk($sformatf("R4 table %0d state", i), fc_state, VEC[i].st);
      chk($sformatf("R5/R13 table %0d gis", i), gis_word, VEC[i].gis);
    end
    rd(3'd2, d); chk("R1 cnt via read", d, 16'h00FE);
    rd(3'd1, d); chk("R4 status state", d, 16'h0002);

    // R7 write-one-to-clear
    wr(3'd4, 16'h07FF);
    chk("R7 gis cleared", gis_word, 0);

    // R6 message lost
    one_pulse(3);
    chk("R6 msg lost", gis_word, 11'h080);
    chk("R9 masked irq", irq, 0);

    // R9 mask
    wr(3'd5, 16'h0080);
    chk("R9 irq on", irq, 1);
    chk("R9 gif", gif_word, 11'h080);
    rd(3'd6, d); chk("R9 gif read", d, 16'h0080);
    wr(3'd5, 16'h0001);
    chk("R9 irq off", irq, 0);

    // R7 set wins over clear
    @(negedge clk);
    ev_msg_lost = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0080;
    @(negedge clk);
    ev_msg_lost = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R7 set wins", gis_word, 11'h080);
    wr(3'd4, 16'h0080);
    chk("R7 clear later", gis_word, 0);

    // R8 error type flags
    one_pulse(0); chk("R8 bit", err_stat, 16'h0040);
    one_pulse(1); chk("R8 form", err_stat, 16'h00C0);
    one_pulse(2); chk("R8 stuff", err_stat, 16'h00C8);
    wr(3'd3, 16'h0040); chk("R8 w1c", err_stat, 16'h0088);
    @(negedge clk);
    ev_stuff_err = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0008;
    @(negedge clk);
    ev_stuff_err = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R8 set wins", err_stat, 16'h0088);

    // R10 configuration handshake
    wr(3'd0, 16'h0080);
    rd(3'd0, d); chk("R10 ack not yet", d, 16'h0000);
    @(negedge clk);
    rd(3'd0, d); chk("R10 ack still low", d, 16'h0000);
    @(negedge clk);
    rd(3'd0, d); chk("R10 ack ctrl", d, 16'h0080);
    rd(3'd1, d); chk("R10 ack stat", d, 16'h0080);
    chk("R10 counters held", cnt_word, 0);
    pulse(5'h03, 2);
    chk("R10 events ignored", cnt_word, 0);
    wr(3'd0, 16'h0000);
    @(negedge clk);
    rd(3'd0, d); chk("R10 ack dropped", d, 16'h0000);
    pulse(5'h02, 1);
    chk("R10 counting resumes", cnt_word, 16'h0001);

    // R11 sleep handshake
    wr(3'd0, 16'h0020);
    rd(3'd7, d); chk("R11 ack not yet", d, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    rd(3'd7, d); chk("R11 sleep ack", d, 16'h0008);
    rd(3'd0, d); chk("R11 req readback", d, 16'h0020);
    wr(3'd7, 16'h0000);
    rd(3'd7, d); chk("R11 leave ack", d, 16'h0000);
    rd(3'd0, d); chk("R11 leave req", d, 16'h0000);

    // R12 software reset
    one_pulse(0);
    one_pulse(3);
    wr(3'd0, 16'h0001);
    chk("R12 cnt", cnt_word, 0);
    chk("R12 gis", gis_word, 0);
    chk("R12 esr", err_stat, 0);
    rd(3'd5, d); chk("R12 gim kept", d, 16'h0001);
    rd(3'd0, d); chk("R12 bit0 reads 0", d, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule